// File: doc/BRIEF.md
# Configurable GPIO Port Pin Controller

This block controls one 8-bit microcontroller I/O port. It keeps an output latch and two per-pin mode registers, all written over a small register bus. For each pin it turns the two mode bits and the latch bit into digital pad controls: a strong low driver, a strong high driver, a weak pull-up, a very weak pull-up and an input enable. The pad level comes back through a two-flop synchronizer. The synchronized level gates the weak pull-up in quasi-bidirectional mode and is what a read of the pin address returns.

The mode pair {mode_hi, mode_lo} selects the pin type. 00 is quasi-bidirectional, 01 is push-pull, 10 is input-only and 11 is open drain. Some pin positions are restricted by parameter. The reset pin position (bit 5) is always input-only. Pins 2 and 3 may only be input-only or open drain: their mode_hi bit is held at 1 and mode_lo picks between the two. In quasi-bidirectional mode, a 0-to-1 change of the latch briefly turns on the strong high driver to speed up the rising edge. The driver then hands over to the pull-ups.

Top module: `gpio_port_ctl`

## Requirements
- R1: After reset the latch reads 0xFF, mode_hi reads 0x2C (the restricted bits forced high) and mode_lo reads 0x00. Every unrestricted pin is then quasi-bidirectional and the restricted pins are input-only.
- R2: In push-pull mode (01) the strong high driver follows the latch and the strong low driver follows its inverse. Both pull-ups are off. The strong low and strong high drivers are never both on for one pin. pad_in_en is 1 for every pin in every mode.
- R3: In quasi-bidirectional mode (00) the very weak pull-up equals the latch bit and the strong low driver equals the inverted latch bit.
- R4: In quasi-bidirectional mode the weak pull-up is on only when the latch bit is 1 and the synchronized pin level is 1.
- R5: In open-drain mode (11) only the strong low driver can be on, equal to the inverted latch bit. In input-only mode (10) no driver and no pull-up is on.
- R6: Bit 5 is always input-only. Writes to bit 5 of either mode register have no effect: it reads back as mode_hi=1, mode_lo=0, and the pin drives nothing.
- R7: For bits 2 and 3, mode_hi is forced to 1 on every write and mode_lo is stored as written. These pins are never quasi-bidirectional or push-pull.
- R8: In quasi-bidirectional mode, a 0-to-1 change of a latch bit turns on that pin's strong high driver for exactly 2 clock cycles: the cycle after the write edge and the cycle after that. It then turns off.
- R9: A change on pad_in shows up at a pin read (address 0) after exactly two rising clock edges.
- R10: Bus addresses: 0 reads the synchronized pins and writes the latch, 1 accesses mode_hi, 2 accesses mode_lo, 3 reads the latch. bus_rdata is combinational from the addressed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pad_in | input | 8 | Raw pad levels |
| pad_drv_lo | output | 8 | Strong low drive enables |
| pad_drv_hi | output | 8 | Strong high drive enables |
| pad_pu_weak | output | 8 | Weak pull-up enables |
| pad_pu_vweak | output | 8 | Very weak pull-up enables |
| pad_in_en | output | 8 | Input buffer enables |

## Verification
The hardest case to reach is the rise boost. It appears only when a latch bit goes from 0 to 1 while its pin is quasi-bidirectional, and it lasts two cycles. The stimulus first writes a pattern with several zero bits, then writes all ones. The scoreboard checks the high drivers on three consecutive cycles after the write edge. A later mode change that leaves the latch unchanged, and rises in push-pull and open-drain modes, confirm that no pulse appears in those cases.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        MODE_QUASI = 2'b00,
        MODE_PUSH  = 2'b01,
        MODE_INPUT = 2'b10,
        MODE_OPEN  = 2'b11
    } pin_mode_e;

    localparam logic [1:0] ADDR_PINS    = 2'd0;
    localparam logic [1:0] ADDR_MODE_HI = 2'd1;
    localparam logic [1:0] ADDR_MODE_LO = 2'd2;
    localparam logic [1:0] ADDR_LATCH   = 2'd3;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] stage1;
        logic [W-1:0] stage2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.stage1 = raw_i;
        s_d.stage2 = s_q.stage1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sync_o = s_q.stage2;
endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_port_pkg::*;
#(
    parameter int           W            = 8,
    parameter logic [W-1:0] IN_ONLY_MASK = 8'h20,
    parameter logic [W-1:0] OD_ONLY_MASK = 8'h0C
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [1:0]   addr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] latch_o,
    output logic [W-1:0] mode_hi_o,
    output logic [W-1:0] mode_lo_o
);
    localparam logic [W-1:0] HI_FORCE = IN_ONLY_MASK | OD_ONLY_MASK;
    localparam logic [W-1:0] LO_KEEP  = ~IN_ONLY_MASK;

    typedef struct packed {
        logic [W-1:0] latch;
        logic [W-1:0] mode_hi;
        logic [W-1:0] mode_lo;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_i) begin
            unique case (addr_i)
                ADDR_PINS:    r_d.latch   = wdata_i;
                ADDR_MODE_HI: r_d.mode_hi = wdata_i | HI_FORCE;
                ADDR_MODE_LO: r_d.mode_lo = wdata_i & LO_KEEP;
                default:      r_d         = r_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.latch   <= '1;
            r_q.mode_hi <= HI_FORCE;
            r_q.mode_lo <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign latch_o   = r_q.latch;
    assign mode_hi_o = r_q.mode_hi;
    assign mode_lo_o = r_q.mode_lo;
endmodule

// File: rtl/gpio_pin_decode.sv
module gpio_pin_decode
    import gpio_port_pkg::*;
#(
    parameter int BOOST_CYC = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  pin_mode_e mode_i,
    input  logic      latch_i,
    input  logic      level_i,
    output logic      drv_lo_o,
    output logic      drv_hi_o,
    output logic      pu_weak_o,
    output logic      pu_vweak_o,
    output logic      in_en_o
);
    localparam int CW = $clog2(BOOST_CYC + 1);
    localparam logic [CW-1:0] RELOAD = CW'(BOOST_CYC - 1);

    typedef struct packed {
        logic          prev_latch;
        logic [CW-1:0] cnt;
    } pin_st_t;

    pin_st_t p_d, p_q;
    logic    quasi, rise, boost;

    always_comb begin
        quasi = (mode_i == MODE_QUASI);
        rise  = latch_i && !p_q.prev_latch;
        boost = quasi && latch_i && (rise || (p_q.cnt != '0));

        p_d            = p_q;
        p_d.prev_latch = latch_i;
        if (!quasi || !latch_i)  p_d.cnt = '0;
        else if (rise)           p_d.cnt = RELOAD;
        else if (p_q.cnt != '0)  p_d.cnt = p_q.cnt - 1'b1;

        drv_lo_o   = 1'b0;
        drv_hi_o   = 1'b0;
        pu_weak_o  = 1'b0;
        pu_vweak_o = 1'b0;
        in_en_o    = 1'b1;
        unique case (mode_i)
            MODE_QUASI: begin
                drv_lo_o   = !latch_i;
                drv_hi_o   = boost;
                pu_vweak_o = latch_i;
                pu_weak_o  = latch_i && level_i;
            end
            MODE_PUSH: begin
                drv_lo_o = !latch_i;
                drv_hi_o = latch_i;
            end
            MODE_OPEN:  drv_lo_o = !latch_i;
            default:    drv_lo_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_q.prev_latch <= 1'b1;
            p_q.cnt        <= '0;
        end else begin
            p_q <= p_d;
        end
    end
endmodule

// File: rtl/gpio_port_ctl.sv
module gpio_port_ctl
    import gpio_port_pkg::*;
#(
    parameter int           W            = 8,
    parameter logic [W-1:0] IN_ONLY_MASK = 8'h20,
    parameter logic [W-1:0] OD_ONLY_MASK = 8'h0C,
    parameter int           BOOST_CYC    = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [1:0]   bus_addr,
    input  logic         bus_wr,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_drv_lo,
    output logic [W-1:0] pad_drv_hi,
    output logic [W-1:0] pad_pu_weak,
    output logic [W-1:0] pad_pu_vweak,
    output logic [W-1:0] pad_in_en
);
    logic [W-1:0] latch_q, mode_hi_q, mode_lo_q, pin_lvl;

    gpio_sync #(.W(W)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pad_in),
        .sync_o (pin_lvl)
    );

    gpio_cfg_regs #(
        .W            (W),
        .IN_ONLY_MASK (IN_ONLY_MASK),
        .OD_ONLY_MASK (OD_ONLY_MASK)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (bus_wr),
        .addr_i    (bus_addr),
        .wdata_i   (bus_wdata),
        .latch_o   (latch_q),
        .mode_hi_o (mode_hi_q),
        .mode_lo_o (mode_lo_q)
    );

    for (genvar i = 0; i < W; i++) begin : g_pin
        gpio_pin_decode #(.BOOST_CYC(BOOST_CYC)) i_dec (
            .clk        (clk),
            .rst_n      (rst_n),
            .mode_i     (pin_mode_e'({mode_hi_q[i], mode_lo_q[i]})),
            .latch_i    (latch_q[i]),
            .level_i    (pin_lvl[i]),
            .drv_lo_o   (pad_drv_lo[i]),
            .drv_hi_o   (pad_drv_hi[i]),
            .pu_weak_o  (pad_pu_weak[i]),
            .pu_vweak_o (pad_pu_vweak[i]),
            .in_en_o    (pad_in_en[i])
        );
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_PINS:    bus_rdata = pin_lvl;
            ADDR_MODE_HI: bus_rdata = mode_hi_q;
            ADDR_MODE_LO: bus_rdata = mode_lo_q;
            default:      bus_rdata = latch_q;
        endcase
    end
endmodule

// File: rtl/gpio_port_ctl_chk.sv
module gpio_port_ctl_chk #(
    parameter int           W            = 8,
    parameter logic [W-1:0] IN_ONLY_MASK = 8'h20,
    parameter logic [W-1:0] OD_ONLY_MASK = 8'h0C,
    parameter int           BOOST_CYC    = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] pad_in,
    input logic [W-1:0] latch_q,
    input logic [W-1:0] mode_hi_q,
    input logic [W-1:0] mode_lo_q,
    input logic [W-1:0] pin_lvl,
    input logic [W-1:0] pad_drv_lo,
    input logic [W-1:0] pad_drv_hi,
    input logic [W-1:0] pad_pu_weak,
    input logic [W-1:0] pad_pu_vweak
);
    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R9: synchronized level lags the pad by two edges
    p_sync_delay_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (pin_lvl == $past(pad_in, 2)));

    for (genvar i = 0; i < W; i++) begin : g_chk
        logic quasi;
        logic [$clog2(BOOST_CYC + 2)-1:0] hi_run;
        assign quasi = !mode_hi_q[i] && !mode_lo_q[i];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  hi_run <= '0;
            else if (!(quasi && pad_drv_hi[i]))          hi_run <= '0;
            else if (hi_run <= ($bits(hi_run))'(BOOST_CYC)) hi_run <= hi_run + 1'b1;
        end

        p_drive_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(pad_drv_lo[i] && pad_drv_hi[i]));

        p_weak_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
            pad_pu_weak[i] |-> (quasi && latch_q[i] && pin_lvl[i]));

        p_vweak_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
            pad_pu_vweak[i] |-> latch_q[i]);

        p_boost_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (quasi && latch_q[i] && !$past(latch_q[i])) |-> pad_drv_hi[i]);

        p_boost_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
            hi_run <= ($bits(hi_run))'(BOOST_CYC));

        if (IN_ONLY_MASK[i]) begin : g_in_only
            p_in_only_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
                !(pad_drv_lo[i] || pad_drv_hi[i] || pad_pu_weak[i] || pad_pu_vweak[i]));
        end
        if (OD_ONLY_MASK[i]) begin : g_od_only
            p_od_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !(pad_drv_hi[i] || pad_pu_weak[i] || pad_pu_vweak[i]));
        end
    end
endmodule

bind gpio_port_ctl gpio_port_ctl_chk #(
    .W            (W),
    .IN_ONLY_MASK (IN_ONLY_MASK),
    .OD_ONLY_MASK (OD_ONLY_MASK),
    .BOOST_CYC    (BOOST_CYC)
) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pad_in       (pad_in),
    .latch_q      (latch_q),
    .mode_hi_q    (mode_hi_q),
    .mode_lo_q    (mode_lo_q),
    .pin_lvl      (pin_lvl),
    .pad_drv_lo   (pad_drv_lo),
    .pad_drv_hi   (pad_drv_hi),
    .pad_pu_weak  (pad_pu_weak),
    .pad_pu_vweak (pad_pu_vweak)
);

// File: tb/test_gpio_port_ctl.sv
`timescale 1ns/1ps
module test_gpio_port_ctl;
    typedef enum int {OBS_RD, OBS_LO, OBS_HI, OBS_WK, OBS_VW, OBS_IE} obs_e;
    typedef struct {
        obs_e       sel;
        logic [7:0] exp;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'hFF;
    logic [7:0] pad_drv_lo, pad_drv_hi, pad_pu_weak, pad_pu_vweak, pad_in_en;

    int total = 0;
    int bad = 0;
    bit done = 0;
    item_t sb[$];

    always #4 clk = ~clk;

    gpio_port_ctl i_gpio_port_ctl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_drv_lo(pad_drv_lo), .pad_drv_hi(pad_drv_hi),
        .pad_pu_weak(pad_pu_weak), .pad_pu_vweak(pad_pu_vweak),
        .pad_in_en(pad_in_en)
    );

    function automatic logic [7:0] observe(obs_e s);
        case (s)
            OBS_RD:  return bus_rdata;
            OBS_LO:  return pad_drv_lo;
            OBS_HI:  return pad_drv_hi;
            OBS_WK:  return pad_pu_weak;
            OBS_VW:  return pad_pu_vweak;
            default: return pad_in_en;
        endcase
    endfunction

    // monitor: compares queued expectations away from the active edge
    always @(negedge clk) begin
        while (sb.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sb.pop_front();
            act = observe(it.sel);
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s sel=%s actual=%02h expected=%02h",
                         it.req, it.sel.name(), act, it.exp);
            end
        end
    end

    task automatic push_exp(obs_e s, logic [7:0] e, string r);
        item_t it;
        it.sel = s; it.exp = e; it.req = r;
        sb.push_back(it);
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        step();
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic read_chk(logic [1:0] a, logic [7:0] e, string r);
        step();
        bus_addr = a;
        push_exp(OBS_RD, e, r);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        repeat (3) step();
        // R1 reset state
        read_chk(2'd3, 8'hFF, "R1");
        read_chk(2'd1, 8'h2C, "R1");
        read_chk(2'd2, 8'h00, "R1");
        push_exp(OBS_VW, 8'hD3, "R1");
        push_exp(OBS_LO, 8'h00, "R1");
        push_exp(OBS_HI, 8'h00, "R1");
        push_exp(OBS_IE, 8'hFF, "R2");
        push_exp(OBS_WK, 8'hD3, "R4");
        // R9 two-edge synchronizer
        step(); pad_in = 8'h0F; bus_addr = 2'd0;
        push_exp(OBS_RD, 8'hFF, "R9");
        step(); push_exp(OBS_RD, 8'hFF, "R9");
        step(); push_exp(OBS_RD, 8'h0F, "R9");
        push_exp(OBS_WK, 8'h03, "R4");
        // R3 quasi-bidirectional drive
        bus_write(2'd0, 8'hA5);
        push_exp(OBS_LO, 8'h52, "R3");
        push_exp(OBS_VW, 8'h81, "R3");
        push_exp(OBS_WK, 8'h01, "R4");
        push_exp(OBS_HI, 8'h00, "R8");
        // R8 rise boost: two cycles, then off
        bus_write(2'd0, 8'hFF);
        push_exp(OBS_HI, 8'h52, "R8");
        step(); push_exp(OBS_HI, 8'h52, "R8");
        step(); push_exp(OBS_HI, 8'h00, "R8");
        // R2 push-pull, R6/R7 coercion
        bus_write(2'd2, 8'hFF);
        bus_write(2'd1, 8'h00);
        read_chk(2'd1, 8'h2C, "R7");
        read_chk(2'd2, 8'hDF, "R6");
        push_exp(OBS_HI, 8'hD3, "R2");
        push_exp(OBS_LO, 8'h00, "R2");
        push_exp(OBS_VW, 8'h00, "R2");
        push_exp(OBS_WK, 8'h00, "R2");
        bus_write(2'd0, 8'h00);
        push_exp(OBS_LO, 8'hDF, "R2");
        push_exp(OBS_HI, 8'h00, "R2");
        // R5 input-only
        bus_write(2'd2, 8'h00);
        bus_write(2'd1, 8'hFF);
        push_exp(OBS_LO, 8'h00, "R5");
        push_exp(OBS_HI, 8'h00, "R5");
        push_exp(OBS_VW, 8'h00, "R5");
        push_exp(OBS_IE, 8'hFF, "R2");
        // R5 open drain
        bus_write(2'd2, 8'hFF);
        push_exp(OBS_LO, 8'hDF, "R5");
        bus_write(2'd0, 8'hF0);
        push_exp(OBS_LO, 8'h0F, "R5");
        push_exp(OBS_HI, 8'h00, "R5");
        push_exp(OBS_VW, 8'h00, "R5");
        // R7 coercion back to quasi; no boost on mode change
        bus_write(2'd1, 8'h00);
        bus_write(2'd2, 8'h00);
        read_chk(2'd1, 8'h2C, "R7");
        push_exp(OBS_LO, 8'h03, "R7");
        push_exp(OBS_HI, 8'h00, "R8");
        push_exp(OBS_VW, 8'hD0, "R3");
        push_exp(OBS_WK, 8'h00, "R4");
        // R10 pin read vs latch read
        read_chk(2'd0, 8'h0F, "R10");
        read_chk(2'd3, 8'hF0, "R10");
        // R4 weak pull-up follows synced level
        step(); pad_in = 8'hFF;
        step(); step();
        push_exp(OBS_WK, 8'hD0, "R4");
        // R8 second boost on low nibble rise
        bus_write(2'd0, 8'hFF);
        push_exp(OBS_HI, 8'h03, "R8");
        step(); push_exp(OBS_HI, 8'h03, "R8");
        step(); push_exp(OBS_HI, 8'h00, "R8");
        step(); step();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule